// File: doc/BRIEF.md
# Light-Load Burst Controller with Latched Level Option

This block is the digital decision logic for light-load burst operation in a fixed-frequency flyback PWM controller. It receives the feedback voltage as a sampled code in millivolts. It also receives a one-cycle VCC turn-on event, a flag that marks a non-isolated supply, a one-millisecond tick and a protection-restart pulse. From these it decides whether the power stage runs in normal mode or in burst mode. It drives a switching-enable, a burst-active flag, the peak-current-limit code, a burst-oscillator select and a slope-compensation enable.

At the VCC turn-on event the feedback level is sampled once to choose one of three options: no burst, low-power burst or high-power burst. That choice then stays fixed until reset. In normal mode the block enters burst mode only after the feedback has stayed below the option's entry level for a full blanking window of millisecond ticks. Inside burst mode it gates switching with a hysteresis pair whose levels depend on the isolated or non-isolated flag. It leaves burst mode at once when the feedback jumps past the exit level.

Top module: `burst_ctrl`

## Requirements
- R1: After reset the block is in normal mode: burst_active=0, sw_en=1, freq_sel=0, slope_en=1 and ilim_code=800. The default option is high-power.
- R2: On the first vcc_on pulse the option is taken from fb_code: below 1730 gives no burst, 1730 through 2890 gives low-power, and above 2890 gives high-power. Later vcc_on pulses do not change it.
- R3: Burst mode is entered only after fb_code stays below the entry level (1030 for high-power, 930 for low-power) during BLANK_MS consecutive ms_tick pulses (default 36). Entry takes effect on the clock edge that samples the last of those ticks.
- R4: If fb_code is at or above the entry level in any cycle of the blanking window, the tick count starts again from zero.
- R5: With the no-burst option selected, burst mode is never entered.
- R6: On entry to burst mode, switching stops (sw_en=0). Inside burst mode, sw_en goes to 1 when fb_code is above the burst-on level and goes to 0 when fb_code is at or below the burst-off level. Between the two levels, sw_en holds its value.
- R7: The burst-on and burst-off levels are 2350 and 2000 when non_iso=0, and 1950 and 1550 when non_iso=1.
- R8: Inside burst mode, fb_code above 2730 returns the block to normal mode on the next edge: burst_active=0, sw_en=1 and ilim_code=800. A value of exactly 2730 does not exit.
- R9: While burst mode is active, ilim_code is 270 for high-power or 220 for low-power, freq_sel=1 and slope_en=0.
- R10: A prot_restart pulse clears burst mode on the next edge and keeps the latched option.
- R11: Until an option has been latched by vcc_on, burst mode is not entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fb_code | input | 12 | Feedback voltage code, 1 mV per LSB |
| vcc_on | input | 1 | One-cycle pulse when VCC reaches turn-on |
| non_iso | input | 1 | 1 selects non-isolated burst hysteresis levels |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| prot_restart | input | 1 | Protection restart pulse |
| sw_en | output | 1 | Switching allowed |
| burst_active | output | 1 | Burst mode active |
| ilim_code | output | 12 | Peak-current-limit code, 1 mV per LSB |
| freq_sel | output | 1 | 1 selects the reduced burst oscillator frequency |
| slope_en | output | 1 | Slope compensation enable |

## Verification
The hardest state to reach from the ports is a blanking window that is one tick short of completion when the feedback briefly rises above the entry level. A counter that only pauses, instead of clearing, would then still enter early. The stimulus gives 35 qualifying ticks, raises the feedback for a single cycle, and then gives 35 more ticks with no entry expected. A further tick must then cause entry. The option boundaries are reached by pulsing vcc_on at feedback codes 1730, 2890 and 2891. Each latched option is told apart only through its effect on entry level and current limit.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int CODE_W = 12;
  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [1:0] {
    OPT_NONE = 2'd0,
    OPT_LOW  = 2'd1,
    OPT_HIGH = 2'd2
  } burst_opt_e;

  typedef enum logic [1:0] {
    ST_NORMAL    = 2'd0,
    ST_BURST_OFF = 2'd1,
    ST_BURST_ON  = 2'd2
  } burst_st_e;

  // Option from the feedback code sampled at turn-on
  function automatic burst_opt_e classify_opt(input code_t fb, input code_t low_min,
                                              input code_t low_max);
    if (fb < low_min)       return OPT_NONE;
    else if (fb <= low_max) return OPT_LOW;
    else                    return OPT_HIGH;
  endfunction

  function automatic code_t entry_level(input burst_opt_e opt, input code_t ent_hi,
                                        input code_t ent_lo);
    case (opt)
      OPT_HIGH: return ent_hi;
      OPT_LOW:  return ent_lo;
      default:  return '0;
    endcase
  endfunction

  function automatic code_t ilim_level(input logic in_burst, input burst_opt_e opt,
                                       input code_t norm, input code_t hi, input code_t lo);
    if (!in_burst)            return norm;
    else if (opt == OPT_LOW)  return lo;
    else                      return hi;
  endfunction
endpackage

// File: rtl/bc_option_latch.sv
module bc_option_latch
  import burst_pkg::*;
#(
  parameter code_t LOW_MIN = 12'd1730,
  parameter code_t LOW_MAX = 12'd2890
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_on,
  input  code_t      fb_code,
  output burst_opt_e opt,
  output logic       frozen
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt    <= OPT_HIGH;
      frozen <= 1'b0;
    end else if (vcc_on && !frozen) begin
      opt    <= classify_opt(fb_code, LOW_MIN, LOW_MAX);
      frozen <= 1'b1;
    end
  end

  // R2: once taken, the option never moves
  a_r2_option_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> (frozen && $stable(opt)));
endmodule

// File: rtl/bc_entry_timer.sv
module bc_entry_timer #(
  parameter int BLANK_MS = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic below,
  input  logic ms_tick,
  output logic enter_req
);
  localparam int CNT_W = $clog2(BLANK_MS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLANK_MS - 1);

  logic [CNT_W-1:0] cnt;
  logic             qualify;

  assign qualify   = arm && below;
  assign enter_req = qualify && ms_tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!qualify)   cnt <= '0;
    else if (ms_tick)    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  // R4: a dropout cycle empties the window
  a_r4_window_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    !qualify |=> (cnt == '0));
  // R3: a request only comes on a tick
  a_r3_request_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    enter_req |-> ms_tick);
endmodule

// File: rtl/bc_burst_fsm.sv
module bc_burst_fsm
  import burst_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      restart,
  input  logic      enter_req,
  input  code_t     fb_code,
  input  code_t     on_lvl,
  input  code_t     off_lvl,
  input  code_t     exit_lvl,
  output burst_st_e st
);
  burst_st_e st_nx;
  logic      in_burst;
  logic      exit_hit;

  assign in_burst = (st != ST_NORMAL);
  assign exit_hit = fb_code > exit_lvl;

  always_comb begin
    st_nx = st;
    if (!in_burst) begin
      if (enter_req && !restart) st_nx = ST_BURST_OFF;
    end else if (restart || exit_hit) begin
      st_nx = ST_NORMAL;
    end else if (fb_code > on_lvl) begin
      st_nx = ST_BURST_ON;
    end else if (fb_code <= off_lvl) begin
      st_nx = ST_BURST_OFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_NORMAL;
    else        st <= st_nx;
  end

  // R6: reaching the off level stops switching
  a_r6_off_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (in_burst && !restart && (fb_code <= off_lvl)) |=> (st == ST_BURST_OFF));
  // R8: a load step ends burst mode
  a_r8_exit_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_burst && exit_hit) |=> (st == ST_NORMAL));
  // R10: restart always leaves burst mode
  a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (st == ST_NORMAL));
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int    BLANK_MS    = 36,
  parameter code_t ENTRY_HI    = 12'd1030,
  parameter code_t ENTRY_LO    = 12'd930,
  parameter code_t ISO_ON      = 12'd2350,
  parameter code_t ISO_OFF     = 12'd2000,
  parameter code_t NISO_ON     = 12'd1950,
  parameter code_t NISO_OFF    = 12'd1550,
  parameter code_t EXIT_LVL    = 12'd2730,
  parameter code_t OPT_LOW_MIN = 12'd1730,
  parameter code_t OPT_LOW_MAX = 12'd2890,
  parameter code_t ILIM_NORM   = 12'd800,
  parameter code_t ILIM_HI     = 12'd270,
  parameter code_t ILIM_LO     = 12'd220
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] fb_code,
  input  logic              vcc_on,
  input  logic              non_iso,
  input  logic              ms_tick,
  input  logic              prot_restart,
  output logic              sw_en,
  output logic              burst_active,
  output logic [CODE_W-1:0] ilim_code,
  output logic              freq_sel,
  output logic              slope_en
);
  burst_opt_e opt;
  logic       opt_frozen;
  burst_st_e  st;
  code_t      ent_lvl;
  code_t      on_lvl;
  code_t      off_lvl;
  logic       below_entry;
  logic       entry_armed;
  logic       enter_req;

  bc_option_latch #(.LOW_MIN(OPT_LOW_MIN), .LOW_MAX(OPT_LOW_MAX)) i_opt (
    .clk(clk), .rst_n(rst_n), .vcc_on(vcc_on), .fb_code(fb_code),
    .opt(opt), .frozen(opt_frozen)
  );

  assign ent_lvl     = entry_level(opt, ENTRY_HI, ENTRY_LO);
  assign below_entry = fb_code < ent_lvl;
  assign entry_armed = opt_frozen && (opt != OPT_NONE) && (st == ST_NORMAL) && !prot_restart;
  assign on_lvl      = non_iso ? NISO_ON  : ISO_ON;
  assign off_lvl     = non_iso ? NISO_OFF : ISO_OFF;

  bc_entry_timer #(.BLANK_MS(BLANK_MS)) i_timer (
    .clk(clk), .rst_n(rst_n), .arm(entry_armed), .below(below_entry),
    .ms_tick(ms_tick), .enter_req(enter_req)
  );

  bc_burst_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .restart(prot_restart), .enter_req(enter_req),
    .fb_code(fb_code), .on_lvl(on_lvl), .off_lvl(off_lvl), .exit_lvl(EXIT_LVL),
    .st(st)
  );

  assign burst_active = (st != ST_NORMAL);
  assign sw_en        = (st != ST_BURST_OFF);
  assign freq_sel     = burst_active;
  assign slope_en     = !burst_active;
  assign ilim_code    = ilim_level(burst_active, opt, ILIM_NORM, ILIM_HI, ILIM_LO);

  // R3: entry is preceded by a low feedback cycle
  a_r3_entry_from_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_active) |-> $past(below_entry));
  // R5: the no-burst option never shows burst mode
  a_r5_none_stays_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (opt == OPT_NONE) |-> !burst_active);
  // R11: no burst before an option is taken
  a_r11_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !opt_frozen |-> !burst_active);
  // R9: reduced current limit while bursting
  a_r9_reduced_limit: assert property (@(posedge clk) disable iff (!rst_n)
    burst_active |-> (ilim_code < ILIM_NORM));
endmodule

// File: tb/test_burst_ctrl.sv
module test_burst_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] fb_code = '0;
  logic        vcc_on = 1'b0;
  logic        non_iso = 1'b0;
  logic        ms_tick = 1'b0;
  logic        prot_restart = 1'b0;
  logic        sw_en, burst_active, freq_sel, slope_en;
  logic [11:0] ilim_code;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  burst_ctrl i_burst_ctrl (
    .clk(clk), .rst_n(rst_n), .fb_code(fb_code), .vcc_on(vcc_on), .non_iso(non_iso),
    .ms_tick(ms_tick), .prot_restart(prot_restart), .sw_en(sw_en),
    .burst_active(burst_active), .ilim_code(ilim_code), .freq_sel(freq_sel),
    .slope_en(slope_en)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fb_code = 12'd2500; vcc_on = 0; non_iso = 0; ms_tick = 0; prot_restart = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_fb(input int v);
    @(negedge clk); fb_code = 12'(v);
    @(negedge clk);
  endtask

  task automatic pulse_vcc(input int v);
    @(negedge clk); fb_code = 12'(v); vcc_on = 1'b1;
    @(negedge clk); vcc_on = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ms_tick = 1'b1;
      @(negedge clk); ms_tick = 1'b0;
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1", "burst_active", burst_active, 0);
    check("R1", "sw_en", sw_en, 1);
    check("R1", "freq_sel", freq_sel, 0);
    check("R1", "slope_en", slope_en, 1);
    check("R1", "ilim_code", ilim_code, 800);
  endtask

  task automatic t_high_iso();
    do_reset();
    pulse_vcc(3000);
    set_fb(1000);
    ticks(35);
    check("R3", "no entry after 35 ticks", burst_active, 0);
    ticks(1);
    check("R3", "entry after 36 ticks", burst_active, 1);
    check("R6", "sw_en off at entry", sw_en, 0);
    check("R9", "high ilim", ilim_code, 270);
    check("R9", "freq_sel", freq_sel, 1);
    check("R9", "slope_en", slope_en, 0);
    set_fb(2350);
    check("R7", "iso on level not exceeded", sw_en, 0);
    set_fb(2351);
    check("R7", "iso on level exceeded", sw_en, 1);
    set_fb(2100);
    check("R6", "hold between levels", sw_en, 1);
    set_fb(2000);
    check("R7", "iso off level", sw_en, 0);
    set_fb(2730);
    check("R8", "2730 stays in burst", burst_active, 1);
    set_fb(2731);
    check("R8", "exit burst", burst_active, 0);
    check("R8", "sw_en after exit", sw_en, 1);
    check("R8", "ilim after exit", ilim_code, 800);
  endtask

  task automatic t_low_noniso();
    do_reset();
    non_iso = 1'b1;
    pulse_vcc(2000);
    pulse_vcc(3000);
    set_fb(1000);
    ticks(40);
    check("R2", "second vcc_on ignored, low level", burst_active, 0);
    set_fb(900);
    ticks(35);
    set_fb(1000);
    set_fb(900);
    ticks(35);
    check("R4", "dropout restarts window", burst_active, 0);
    ticks(1);
    check("R4", "entry after full window", burst_active, 1);
    check("R2", "low ilim", ilim_code, 220);
    set_fb(1951);
    check("R7", "non-iso on", sw_en, 1);
    set_fb(1600);
    check("R6", "hold between non-iso levels", sw_en, 1);
    set_fb(1550);
    check("R7", "non-iso off", sw_en, 0);
    set_fb(900);
    @(negedge clk); prot_restart = 1'b1;
    @(negedge clk); prot_restart = 1'b0;
    check("R10", "restart clears burst", burst_active, 0);
    check("R10", "ilim after restart", ilim_code, 800);
    ticks(36);
    check("R10", "option kept", ilim_code, 220);
  endtask

  task automatic t_none_and_bounds();
    do_reset();
    pulse_vcc(1000);
    set_fb(500);
    ticks(50);
    check("R5", "no-burst option", burst_active, 0);
    do_reset();
    pulse_vcc(1729);
    set_fb(500);
    ticks(40);
    check("R5", "1729 gives no burst", burst_active, 0);
    do_reset();
    pulse_vcc(1730);
    set_fb(950);
    ticks(40);
    check("R2", "1730 gives low", burst_active, 0);
    do_reset();
    pulse_vcc(2890);
    set_fb(950);
    ticks(40);
    check("R2", "2890 gives low", burst_active, 0);
    do_reset();
    pulse_vcc(2891);
    set_fb(950);
    ticks(36);
    check("R2", "2891 gives high", burst_active, 1);
    check("R2", "2891 high ilim", ilim_code, 270);
  endtask

  task automatic t_no_latch();
    do_reset();
    set_fb(500);
    ticks(40);
    check("R11", "no entry before latch", burst_active, 0);
  endtask

  initial begin
    t_reset_state();
    t_high_iso();
    t_low_noniso();
    t_none_and_bounds();
    t_no_latch();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule